// File: doc/BRIEF.md
# Transfer Length Sequencer

This block works out how many bytes one transfer operation of a bus-storage controller moves, and then moves them. It holds a 16-bit programmed byte count, written in two byte halves. On a start pulse it combines that count with a signed residual size and a command-phase flag to fix the operation length. A positive residual means data flows from the device to the host. A negative residual means data flows toward the device. In command phase the length is capped at 32 bytes.

The bytes are moved over a one-byte request/acknowledge DMA channel. In the data phase, each burst is limited to what the device reports as buffered through a data-ready event. When the device has nothing buffered, the sequencer waits. When a burst empties the device buffer exactly, the sequencer pulses a take strobe to ask the device for more data.

Completion sets terminal count, loads the done interrupt code, zeroes the programmed count and raises the interrupt line. The line stays high until it is cleared. Completion can happen at once, or it can wait for the device's next data-ready event, depending on how the last burst ended.

Top module: `xfer_len_seq`

## Requirements
- R1: The effective count is count-low plus count-mid times 256. A programmed count of zero means 65536 bytes.
- R2: With the command-phase flag set, the length is the smaller of the effective count and 32. The direction output `dma_dir` is 1 (toward the device). Bytes move without waiting for device data, and completion follows the last byte.
- R3: With the command-phase flag clear, the length is the smaller of the effective count and the magnitude of the residual. `dma_dir` is 1 when the residual is negative and 0 otherwise.
- R4: A start clears terminal count. A start during an active operation abandons it and reloads length, remaining count and residual from the new inputs.
- R5: A write of either count byte updates `count_out` and clears terminal count.
- R6: On completion, `tc` becomes 1, `intr_code` becomes 0x10, `count_out` becomes 0 and `irq` becomes 1. `irq` stays 1 until a cycle with `irq_clear` high.
- R7: Each cycle with `dma_req` and `dma_ack` both high moves one byte. It lowers `remaining` by one. In the data phase it also moves `residual_out` one step toward zero: +1 toward the device, -1 from the device.
- R8: In the data phase, a burst never exceeds the bytes the device reported. With no bytes buffered and length still to move, `dma_req` stays low until a data-ready event arrives.
- R9: A burst that leaves bytes in the device buffer completes the operation at once.
- R10: A burst that empties the device buffer exactly pulses `dev_take` for one cycle. The operation then completes only if data flows from the device, `remaining` is 0 and the residual is still positive. Otherwise it waits. A later data-ready event with `remaining` 0 and a residual of zero or below completes it.
- R11: After reset, `tc`, `irq`, `intr_code`, `count_out`, `dma_req` and `dev_take` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_lo_we | input | 1 | Write `cnt_wdata` into count bits 7:0 |
| cnt_mid_we | input | 1 | Write `cnt_wdata` into count bits 15:8 |
| cnt_wdata | input | 8 | Count write data |
| start | input | 1 | Begin a transfer operation |
| cmd_phase | input | 1 | Operation is a command-phase transfer |
| residual_in | input | 20 | Signed residual size sampled at start |
| dev_ready | input | 1 | Device data-ready event |
| dev_len | input | 17 | Bytes the device has buffered |
| dma_ack | input | 1 | Byte acknowledge from memory side |
| irq_clear | input | 1 | Lower the interrupt line |
| dma_req | output | 1 | Byte request |
| dma_dir | output | 1 | 1 = toward device, 0 = from device |
| dev_take | output | 1 | One-cycle pulse: device buffer drained |
| xfer_len | output | 17 | Length fixed at the last start |
| remaining | output | 17 | Bytes still to move |
| residual_out | output | 20 | Signed residual, updated per byte |
| count_out | output | 16 | Programmed count register |
| tc | output | 1 | Terminal count status |
| irq | output | 1 | Interrupt line |
| intr_code | output | 8 | Interrupt code |

## Verification
`xfer_len`, `remaining`, `residual_out` and the cleared `tc` follow one clock edge after a start. `dma_req` rises one edge later, after the decision state. Each acknowledged byte updates `remaining` and `residual_out` at that same edge. The completion effects and `dev_take` appear one edge after the final acknowledge or the qualifying data-ready event. The bench reference model advances on the same rising edge as the design and compares every output at the following falling edge, so each result is read in exactly the cycle it is due. Directed checks sample at falling edges counted from the stimulus.

// File: rtl/xls_pkg.sv
package xls_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_KICK = 2'd1,
        ST_MOVE = 2'd2,
        ST_WAIT = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic to_dev;
        logic cmd;
    } xfer_mode_t;

    localparam logic [7:0] INTR_DONE = 8'h10;

endpackage

// File: rtl/xls_len_calc.sv
module xls_len_calc #(
    parameter int CNT_W   = 16,
    parameter int RES_W   = 20,
    parameter int CMD_MAX = 32
) (
    input  logic [CNT_W-1:0]        cnt,
    input  logic signed [RES_W-1:0] res,
    input  logic                    cmd,
    output logic [CNT_W:0]          len,
    output logic                    to_dev
);
    localparam int LEN_W = CNT_W + 1;
    localparam int CMP_W = (RES_W + 1 > LEN_W) ? RES_W + 1 : LEN_W;
    localparam logic [LEN_W-1:0] CMD_CAP = LEN_W'(CMD_MAX);

    logic [LEN_W-1:0]        eff;
    logic signed [RES_W:0]   res_x;
    logic [RES_W:0]          mag;
    logic [CMP_W-1:0]        eff_c;
    logic [CMP_W-1:0]        mag_c;

    always_comb begin
        eff   = (cnt == '0) ? (LEN_W'(1) << CNT_W) : {1'b0, cnt};
        res_x = {res[RES_W-1], res};
        mag   = (res_x < 0) ? RES_W'(0) - res_x : res_x;
        mag   = res_x[RES_W] ? (~res_x + 1'b1) : res_x;
        eff_c = CMP_W'(eff);
        mag_c = CMP_W'(mag);
        if (cmd)
            len = (eff < CMD_CAP) ? eff : CMD_CAP;
        else
            len = (eff_c < mag_c) ? eff : LEN_W'(mag_c);
        to_dev = cmd | res[RES_W-1];
    end

endmodule

// File: rtl/xls_status.sv
module xls_status
    import xls_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lo_we,
    input  logic             mid_we,
    input  logic [7:0]       wdata,
    input  logic             start,
    input  logic             done,
    input  logic             irq_clear,
    output logic [CNT_W-1:0] cnt,
    output logic             tc,
    output logic             irq,
    output logic [7:0]       code
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tc   <= 1'b0;
            irq  <= 1'b0;
            code <= '0;
        end else begin
            if (lo_we)
                cnt[7:0] <= wdata;
            if (mid_we)
                cnt[CNT_W-1:8] <= wdata[CNT_W-9:0];
            if (lo_we || mid_we || start)
                tc <= 1'b0;
            if (irq_clear)
                irq <= 1'b0;
            if (done) begin
                tc   <= 1'b1;
                irq  <= 1'b1;
                code <= INTR_DONE;
                cnt  <= '0;
            end
        end
    end

    // R4: a start always leaves terminal count clear
    a_r4_start_clears_tc: assert property (@(posedge clk) disable iff (rst)
        start |=> !tc);

    // R5: a count write without a completion clears terminal count
    a_r5_write_clears_tc: assert property (@(posedge clk) disable iff (rst)
        ((lo_we || mid_we) && !done) |=> !tc);

    // R6: completion effects land together
    a_r6_done_effects: assert property (@(posedge clk) disable iff (rst)
        done |=> (tc && irq && code == INTR_DONE && cnt == '0));

    // R6: the line only drops on a clear request
    a_r6_irq_hold: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(irq_clear));

endmodule

// File: rtl/xls_engine.sv
module xls_engine
    import xls_pkg::*;
#(
    parameter int LEN_W   = 17,
    parameter int RES_W   = 20,
    parameter int CMD_MAX = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [LEN_W-1:0]        len_in,
    input  xfer_mode_t              mode_in,
    input  logic signed [RES_W-1:0] res_in,
    input  logic                    dev_ready,
    input  logic [LEN_W-1:0]        dev_len,
    input  logic                    dma_ack,
    output logic                    dma_req,
    output logic                    dma_dir,
    output logic                    dev_take,
    output logic                    done,
    output logic [LEN_W-1:0]        remaining,
    output logic [LEN_W-1:0]        xfer_len,
    output logic signed [RES_W-1:0] residual
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    seq_state_t              st_q;
    xfer_mode_t              mode_q;
    logic [LEN_W-1:0]        rem_q, xlen_q, chunk_q, dev_q;
    logic signed [RES_W-1:0] res_q;
    logic                    take_q;

    logic                    last_beat;
    logic [LEN_W-1:0]        dev_after, rem_after;
    logic signed [RES_W-1:0] res_after;

    always_comb begin
        last_beat = (st_q == ST_MOVE) && dma_ack && (chunk_q == ONE);
        rem_after = rem_q - ONE;
        dev_after = mode_q.cmd ? dev_q : dev_q - ONE;
        if (mode_q.cmd)
            res_after = res_q;
        else if (mode_q.to_dev)
            res_after = res_q + RES_W'(1);
        else
            res_after = res_q - RES_W'(1);

        done = 1'b0;
        if (!start) begin
            case (st_q)
                ST_KICK: done = !mode_q.cmd && dev_q != '0 && rem_q == '0;
                ST_MOVE: done = last_beat &&
                                (mode_q.cmd || dev_after != '0 ||
                                 (!mode_q.to_dev && rem_after == '0 && res_after > 0));
                ST_WAIT: done = dev_ready && rem_q == '0 && res_q <= 0;
                default: done = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            mode_q  <= '0;
            rem_q   <= '0;
            xlen_q  <= '0;
            chunk_q <= '0;
            dev_q   <= '0;
            res_q   <= '0;
            take_q  <= 1'b0;
        end else begin
            take_q <= last_beat && !mode_q.cmd && dev_after == '0;
            if (start) begin
                rem_q   <= len_in;
                xlen_q  <= len_in;
                res_q   <= res_in;
                mode_q  <= mode_in;
                chunk_q <= '0;
                st_q    <= ST_KICK;
            end else begin
                case (st_q)
                    ST_IDLE: begin
                        if (dev_ready)
                            dev_q <= dev_len;
                    end
                    ST_KICK: begin
                        if (mode_q.cmd) begin
                            chunk_q <= rem_q;
                            st_q    <= ST_MOVE;
                        end else if (dev_q == '0) begin
                            st_q <= ST_WAIT;
                        end else if (rem_q == '0) begin
                            st_q <= ST_IDLE;
                        end else begin
                            chunk_q <= (rem_q < dev_q) ? rem_q : dev_q;
                            st_q    <= ST_MOVE;
                        end
                    end
                    ST_MOVE: begin
                        if (dma_ack) begin
                            chunk_q <= chunk_q - ONE;
                            rem_q   <= rem_after;
                            dev_q   <= dev_after;
                            res_q   <= res_after;
                            if (chunk_q == ONE)
                                st_q <= done ? ST_IDLE : ST_WAIT;
                        end
                    end
                    default: begin
                        if (dev_ready) begin
                            dev_q <= dev_len;
                            if (rem_q != '0)
                                st_q <= ST_KICK;
                            else if (res_q <= 0)
                                st_q <= ST_IDLE;
                        end
                    end
                endcase
            end
        end
    end

    assign dma_req   = (st_q == ST_MOVE);
    assign dma_dir   = mode_q.to_dev;
    assign dev_take  = take_q;
    assign remaining = rem_q;
    assign xfer_len  = xlen_q;
    assign residual  = res_q;

    // R7: every acknowledged byte lowers the remaining count by one
    a_r7_beat_count: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_MOVE && dma_ack && !start) |=> rem_q == $past(rem_q) - ONE);

    // R7: remaining never exceeds the fixed length
    a_r7_rem_bound: assert property (@(posedge clk) disable iff (rst)
        rem_q <= xlen_q);

    // R8: a data burst never outruns the device buffer
    a_r8_chunk_fits: assert property (@(posedge clk) disable iff (rst)
        (dma_req && !mode_q.cmd) |-> chunk_q <= dev_q);

    // R2: command phase length is capped
    a_r2_cmd_cap: assert property (@(posedge clk) disable iff (rst)
        (mode_q.cmd && st_q != ST_IDLE) |-> xlen_q <= LEN_W'(CMD_MAX));

endmodule

// File: rtl/xfer_len_seq.sv
module xfer_len_seq
    import xls_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int RES_W   = 20,
    parameter int CMD_MAX = 32,
    localparam int LEN_W  = CNT_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cnt_lo_we,
    input  logic                    cnt_mid_we,
    input  logic [7:0]              cnt_wdata,
    input  logic                    start,
    input  logic                    cmd_phase,
    input  logic signed [RES_W-1:0] residual_in,
    input  logic                    dev_ready,
    input  logic [LEN_W-1:0]        dev_len,
    input  logic                    dma_ack,
    input  logic                    irq_clear,
    output logic                    dma_req,
    output logic                    dma_dir,
    output logic                    dev_take,
    output logic [LEN_W-1:0]        xfer_len,
    output logic [LEN_W-1:0]        remaining,
    output logic signed [RES_W-1:0] residual_out,
    output logic [CNT_W-1:0]        count_out,
    output logic                    tc,
    output logic                    irq,
    output logic [7:0]              intr_code
);
    logic [LEN_W-1:0] calc_len;
    logic             calc_to_dev;
    logic             done;
    xfer_mode_t       mode;

    assign mode.to_dev = calc_to_dev;
    assign mode.cmd    = cmd_phase;

    xls_len_calc #(.CNT_W(CNT_W), .RES_W(RES_W), .CMD_MAX(CMD_MAX)) u_calc (
        .cnt    (count_out),
        .res    (residual_in),
        .cmd    (cmd_phase),
        .len    (calc_len),
        .to_dev (calc_to_dev)
    );

    xls_engine #(.LEN_W(LEN_W), .RES_W(RES_W), .CMD_MAX(CMD_MAX)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .len_in    (calc_len),
        .mode_in   (mode),
        .res_in    (residual_in),
        .dev_ready (dev_ready),
        .dev_len   (dev_len),
        .dma_ack   (dma_ack),
        .dma_req   (dma_req),
        .dma_dir   (dma_dir),
        .dev_take  (dev_take),
        .done      (done),
        .remaining (remaining),
        .xfer_len  (xfer_len),
        .residual  (residual_out)
    );

    xls_status #(.CNT_W(CNT_W)) u_status (
        .clk       (clk),
        .rst       (rst),
        .lo_we     (cnt_lo_we),
        .mid_we    (cnt_mid_we),
        .wdata     (cnt_wdata),
        .start     (start),
        .done      (done),
        .irq_clear (irq_clear),
        .cnt       (count_out),
        .tc        (tc),
        .irq       (irq),
        .code      (intr_code)
    );

endmodule

// File: tb/xfer_len_seq_test.sv
module xfer_len_seq_test;
    localparam int CNT_W = 16;
    localparam int RES_W = 20;
    localparam int LEN_W = CNT_W + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cnt_lo_we = 0, cnt_mid_we = 0, start = 0, cmd_phase = 0;
    logic dev_ready = 0, dma_ack = 0, irq_clear = 0;
    logic [7:0] cnt_wdata = '0;
    logic signed [RES_W-1:0] residual_in = '0;
    logic [LEN_W-1:0] dev_len = '0;
    logic dma_req, dma_dir, dev_take, tc, irq;
    logic [LEN_W-1:0] xfer_len, remaining;
    logic signed [RES_W-1:0] residual_out;
    logic [CNT_W-1:0] count_out;
    logic [7:0] intr_code;

    int n_chk = 0, n_fail = 0;
    bit finished = 0, live = 0, saw_take = 0;

    always #4 clk = ~clk;

    xfer_len_seq uut (
        .clk(clk), .rst(rst), .cnt_lo_we(cnt_lo_we), .cnt_mid_we(cnt_mid_we),
        .cnt_wdata(cnt_wdata), .start(start), .cmd_phase(cmd_phase),
        .residual_in(residual_in), .dev_ready(dev_ready), .dev_len(dev_len),
        .dma_ack(dma_ack), .irq_clear(irq_clear), .dma_req(dma_req),
        .dma_dir(dma_dir), .dev_take(dev_take), .xfer_len(xfer_len),
        .remaining(remaining), .residual_out(residual_out), .count_out(count_out),
        .tc(tc), .irq(irq), .intr_code(intr_code)
    );

    task automatic chk(string tag, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Reference model state (0 idle, 1 decide, 2 move, 3 wait)
    int m_st, m_cnt, m_rem, m_xlen, m_chunk, m_dev, m_res, m_code;
    bit m_tc, m_irq, m_take, m_todev, m_cmd;
    int e_eff, e_mag, e_len, e_dev, e_rem, e_res;
    bit e_dn, e_last;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_cnt = 0; m_rem = 0; m_xlen = 0; m_chunk = 0; m_dev = 0;
            m_res = 0; m_code = 0; m_tc = 0; m_irq = 0; m_take = 0;
            m_todev = 0; m_cmd = 0;
        end else begin
            e_dn = 0;
            e_last = (m_st == 2) && dma_ack && (m_chunk == 1);
            e_rem = m_rem - 1;
            e_dev = m_cmd ? m_dev : m_dev - 1;
            e_res = m_cmd ? m_res : (m_todev ? m_res + 1 : m_res - 1);
            m_take = e_last && !m_cmd && e_dev == 0;
            if (start) begin
                e_eff = (m_cnt == 0) ? 65536 : m_cnt;
                e_mag = (int'(residual_in) < 0) ? -int'(residual_in) : int'(residual_in);
                if (cmd_phase) e_len = (e_eff < 32) ? e_eff : 32;
                else           e_len = (e_eff < e_mag) ? e_eff : e_mag;
                m_rem = e_len; m_xlen = e_len; m_res = int'(residual_in);
                m_cmd = cmd_phase; m_todev = cmd_phase || int'(residual_in) < 0;
                m_chunk = 0; m_st = 1;
            end else if (m_st == 0) begin
                if (dev_ready) m_dev = int'(dev_len);
            end else if (m_st == 1) begin
                if (m_cmd) begin m_chunk = m_rem; m_st = 2; end
                else if (m_dev == 0) m_st = 3;
                else if (m_rem == 0) begin e_dn = 1; m_st = 0; end
                else begin m_chunk = (m_rem < m_dev) ? m_rem : m_dev; m_st = 2; end
            end else if (m_st == 2) begin
                if (dma_ack) begin
                    m_chunk--; m_rem = e_rem; m_dev = e_dev; m_res = e_res;
                    if (e_last) begin
                        e_dn = m_cmd || e_dev != 0 || (!m_todev && e_rem == 0 && e_res > 0);
                        m_st = e_dn ? 0 : 3;
                    end
                end
            end else begin
                if (dev_ready) begin
                    m_dev = int'(dev_len);
                    if (m_rem != 0) m_st = 1;
                    else if (m_res <= 0) begin e_dn = 1; m_st = 0; end
                end
            end
            if (cnt_lo_we) m_cnt = (m_cnt & 32'hff00) | int'(cnt_wdata);
            if (cnt_mid_we) m_cnt = (m_cnt & 32'h00ff) | (int'(cnt_wdata) << 8);
            if (cnt_lo_we || cnt_mid_we || start) m_tc = 0;
            if (irq_clear) m_irq = 0;
            if (e_dn) begin m_tc = 1; m_irq = 1; m_code = 16; m_cnt = 0; end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (live && !rst) begin
            chk("R8", "dma_req", dma_req, m_st == 2);
            chk("R6", "tc", tc, m_tc);
            chk("R6", "irq", irq, m_irq);
            chk("R6", "intr_code", intr_code, m_code);
            chk("R5", "count_out", count_out, m_cnt);
            chk("R7", "remaining", remaining, m_rem);
            chk("R7", "residual_out", residual_out, m_res);
            chk("R10", "dev_take", dev_take, m_take);
            chk(m_cmd ? "R2" : "R3", "xfer_len", xfer_len, m_xlen);
            if (m_st != 0) chk("R3", "dma_dir", dma_dir, m_todev);
            if (dev_take) saw_take = 1;
        end
    end

    // Acknowledge generator: stalls one cycle in three
    int ack_ph = 0;
    always @(negedge clk) begin
        ack_ph = (ack_ph + 1) % 3;
        dma_ack <= dma_req && (ack_ph != 0);
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cnt(int v);
        @(negedge clk); cnt_lo_we = 1; cnt_wdata = 8'(v);
        @(negedge clk); cnt_lo_we = 0; cnt_mid_we = 1; cnt_wdata = 8'(v >> 8);
        @(negedge clk); cnt_mid_we = 0;
    endtask

    task automatic go(bit cmd, int res);
        @(negedge clk); start = 1; cmd_phase = cmd; residual_in = RES_W'(res);
        @(negedge clk); start = 0;
    endtask

    task automatic dev(int n);
        @(negedge clk); dev_ready = 1; dev_len = LEN_W'(n);
        @(negedge clk); dev_ready = 0;
    endtask

    task automatic wait_irq(string tag);
        int k = 0;
        while (!irq && k < 3000) begin @(negedge clk); k++; end
        chk(tag, "completion reached", irq, 1);
    endtask

    task automatic clr_irq();
        @(negedge clk); irq_clear = 1;
        @(negedge clk); irq_clear = 0;
        chk("R6", "irq after clear", irq, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 0;
        tick(1);
        live = 1;
        chk("R11", "tc", tc, 0);
        chk("R11", "irq", irq, 0);
        chk("R11", "intr_code", intr_code, 0);
        chk("R11", "count_out", count_out, 0);
        chk("R11", "dma_req", dma_req, 0);
        chk("R11", "dev_take", dev_take, 0);

        // Command phase, short count
        wr_cnt(5);
        chk("R5", "count after write", count_out, 5);
        go(1, 0);
        chk("R2", "cmd len", xfer_len, 5);
        chk("R2", "cmd dir", dma_dir, 1);
        wait_irq("R2");
        chk("R6", "tc at done", tc, 1);
        chk("R6", "code at done", intr_code, 8'h10);
        chk("R6", "count cleared", count_out, 0);
        tick(2);
        chk("R6", "irq held", irq, 1);
        clr_irq();

        // Command phase capped at 32
        wr_cnt(16'h0100);
        go(1, 0);
        chk("R2", "cmd cap", xfer_len, 32);
        wait_irq("R2");
        clr_irq();

        // Zero count means 65536, then abort with a new start
        go(0, 70000);
        chk("R1", "zero count length", xfer_len, 65536);
        chk("R4", "tc cleared by start", tc, 0);
        go(0, 100);
        chk("R4", "reload length", xfer_len, 100);
        chk("R4", "reload residual", residual_out, 100);
        tick(6);
        chk("R8", "no request without data", dma_req, 0);
        saw_take = 0;
        dev(40);
        tick(80);
        chk("R10", "take pulse on exact drain", saw_take, 1);
        chk("R10", "no early done", irq, 0);
        chk("R7", "remaining after burst", remaining, 60);
        dev(100);
        wait_irq("R9");
        chk("R9", "residual after partial", residual_out, 0);
        clr_irq();

        // Toward the device, two bursts, deferred completion
        dev(0);
        wr_cnt(10);
        go(0, -10);
        chk("R3", "to-device dir", dma_dir, 1);
        tick(5);
        chk("R8", "waits for space", dma_req, 0);
        dev(4);
        tick(20);
        dev(6);
        tick(30);
        chk("R10", "deferred to-device", irq, 0);
        chk("R7", "residual to zero", residual_out, 0);
        dev(1);
        tick(1);
        chk("R10", "done on data-ready", irq, 1);
        clr_irq();

        // From the device, exact drain, residual zero: deferred
        dev(0);
        wr_cnt(8);
        go(0, 8);
        chk("R3", "from-device dir", dma_dir, 0);
        dev(8);
        tick(30);
        chk("R10", "deferred from-device", irq, 0);
        dev(5);
        tick(1);
        chk("R10", "done on next ready", irq, 1);
        clr_irq();

        // Count write clears terminal count
        wr_cnt(4);
        chk("R5", "tc cleared by write", tc, 0);
        chk("R5", "count after write", count_out, 4);

        // Leftover device data: partial drain completes at once
        go(0, 10);
        wait_irq("R9");
        clr_irq();

        // From the device, exact drain with residual still positive
        dev(0);
        wr_cnt(4);
        go(0, 10);
        dev(4);
        wait_irq("R10");
        chk("R10", "residual left", residual_out, 6);
        clr_irq();
        tick(4);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule